// File: doc/BRIEF.md
# Shared Serial-Flash Access Arbiter

This block lets two masters share one configuration-flash pin set: the user's core logic and a programming bridge driven from a JTAG path. The user side is the master of the arrangement. The bridge asks for the pins by raising a request. The user side answers with an asynchronous grant, and the arbiter hands the flash clock, the chip selects, the output data and the output enables to whichever master currently owns them. Data returning from the flash goes to the core at all times.

The grant crosses into the flash clock domain through a two-flop synchronizer. Ownership is held in a register. It changes only while the master that holds the pins has every chip select deasserted. Each change is followed by a short quiet window in which no master drives the flash. The bridge is told through a go flag when it may toggle the pins. If no grant arrives within a parameterised timeout (five seconds at the configured clock rate), the bridge abandons its request and a sticky flag records the timeout. If the grant is withdrawn while the request is still up, a sticky protocol-error flag is set and the bridge keeps the pins until its operation ends.

Top module: `flash_share_arbiter`

## Requirements
- R1: After reset, req_o, br_go_o, timeout_o and proto_err_o are low and the flash pins follow the user inputs.
- R2: A br_start_i pulse while idle raises req_o after the next clock edge. req_o then stays high until either br_done_i is sampled in the active phase or the timeout fires. A new request may follow directly after a release.
- R3: grant_async_i acts only after two flash-clock flops. When the grant is driven between edges and the user chip selects are all high, the pins show the user for two samples, show the quiet state for two samples, and br_go_o is high at the fifth sample.
- R4: After every change of owner, the pins stay in the quiet state for GAP_CYC (2) cycles: all chip selects high, and clock, data and output enables low.
- R5: Ownership does not move while the current owner holds any chip select low. The move happens on the first edge after all of them are high.
- R6: The flash pins carry the bridge inputs only while the bridge owns them. br_go_o implies req_o. A grant with no pending request has no effect on the pins.
- R7: A request that sees no synchronized grant for TO_CYC = CLK_HZ/1000*TIMEOUT_MS cycles drops req_o after exactly TO_CYC cycles high. timeout_o then sets and stays set until reset, and the bridge never gets the pins.
- R8: A synchronized grant that is low during the active phase sets proto_err_o, which stays set until reset. The bridge keeps the pins and br_go_o until the request falls.
- R9: When the owning master drives more than one chip select low, every fl_cs_n_o bit is driven high (active low, at most one low at any time).
- R10: After br_done_i, req_o falls at the next edge. The pins show the bridge for one more sample, then the quiet state for two samples, and return to the user at the fourth sample.
- R11: core_din_o always equals fl_din_i, whoever owns the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Flash clock; all pin traffic is timed to it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_async_i | input | 1 | Grant from user logic, asynchronous |
| br_start_i | input | 1 | Bridge wants to begin an operation |
| br_done_i | input | 1 | Bridge operation finished |
| req_o | output | 1 | Access request to user logic |
| br_go_o | output | 1 | Bridge may toggle the flash pins |
| timeout_o | output | 1 | Sticky: request abandoned for lack of a grant |
| proto_err_o | output | 1 | Sticky: grant withdrawn during a request |
| usr_sck_i | input | 1 | User flash clock |
| usr_cs_n_i | input | CS_W | User chip selects, active low |
| usr_dout_i | input | DATA_W | User data toward the flash |
| usr_oe_i | input | DATA_W | User data output enables |
| br_sck_i | input | 1 | Bridge flash clock |
| br_cs_n_i | input | CS_W | Bridge chip selects, active low |
| br_dout_i | input | DATA_W | Bridge data toward the flash |
| br_oe_i | input | DATA_W | Bridge data output enables |
| fl_din_i | input | DATA_W | Data from the flash |
| core_din_o | output | DATA_W | Flash data to the core |
| fl_sck_o | output | 1 | Flash clock pin |
| fl_cs_n_o | output | CS_W | Flash chip selects, active low |
| fl_dout_o | output | DATA_W | Data to the flash |
| fl_oe_o | output | DATA_W | Output enables of the data pins |

## Verification
The assertions assume that the bridge honours the handshake: it drives br_done_i only while it is active, and it changes its pins only on the flash clock. They also assume that the bridge chip-select vector is one-hot-low or idle whenever its pin equality is checked. The bench keeps within these limits. It changes every input only on the falling clock edge, it pulses the bridge done only after br_go_o has been seen, and it raises its chip selects before a release. Outside the early-drop scenario, the bench keeps the grant high for the whole request.

// File: rtl/flash_share_pkg.sv
package flash_share_pkg;
  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_WAIT = 2'd1,
    REQ_ACT  = 2'd2
  } req_state_e;

  typedef enum logic {
    OWN_USER   = 1'b0,
    OWN_BRIDGE = 1'b1
  } owner_e;
endpackage

// File: rtl/flash_grant_sync.sv
module flash_grant_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/flash_req_ctrl.sv
module flash_req_ctrl
  import flash_share_pkg::*;
#(
  parameter int unsigned TO_CYC = 500_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic grant_s_i,
  input  logic owner_br_i,
  input  logic blank_i,
  output logic req_o,
  output logic go_o,
  output logic timeout_o,
  output logic proto_err_o
);
  localparam int unsigned CNT_W = $clog2(TO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_CYC - 1);

  req_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             to_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= REQ_IDLE;
      cnt_q   <= '0;
      to_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        REQ_IDLE: if (start_i) begin
          state_q <= REQ_WAIT;
          cnt_q   <= '0;
        end
        REQ_WAIT: begin
          if (grant_s_i) begin
            state_q <= REQ_ACT;
          end else if (cnt_q == CNT_LAST) begin
            state_q <= REQ_IDLE;
            to_q    <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        REQ_ACT: begin
          if (!grant_s_i) err_q <= 1'b1;  // grant withdrawn under request
          if (done_i) state_q <= REQ_IDLE;
        end
        default: state_q <= REQ_IDLE;
      endcase
    end
  end

  assign req_o       = (state_q != REQ_IDLE);
  assign go_o        = (state_q == REQ_ACT) && owner_br_i && !blank_i;
  assign timeout_o   = to_q;
  assign proto_err_o = err_q;
endmodule

// File: rtl/flash_pin_mux.sv
module flash_pin_mux
  import flash_share_pkg::*;
#(
  parameter int unsigned DATA_W  = 4,
  parameter int unsigned CS_W    = 3,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              want_br_i,
  input  logic              usr_sck_i,
  input  logic [CS_W-1:0]   usr_cs_n_i,
  input  logic [DATA_W-1:0] usr_dout_i,
  input  logic [DATA_W-1:0] usr_oe_i,
  input  logic              br_sck_i,
  input  logic [CS_W-1:0]   br_cs_n_i,
  input  logic [DATA_W-1:0] br_dout_i,
  input  logic [DATA_W-1:0] br_oe_i,
  output logic              owner_br_o,
  output logic              blank_o,
  output logic              fl_sck_o,
  output logic [CS_W-1:0]   fl_cs_n_o,
  output logic [DATA_W-1:0] fl_dout_o,
  output logic [DATA_W-1:0] fl_oe_o
);
  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);

  owner_e            owner_q;
  logic [GAP_W-1:0]  gap_q;
  logic [CS_W-1:0]   sel_cs, safe_cs;
  logic              sel_sck, quiet, is_br;
  logic [DATA_W-1:0] sel_dout, sel_oe;

  assign is_br = (owner_q == OWN_BRIDGE);
  assign quiet = &(is_br ? br_cs_n_i : usr_cs_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_USER;
      gap_q   <= '0;
    end else if ((want_br_i != is_br) && quiet) begin
      owner_q <= want_br_i ? OWN_BRIDGE : OWN_USER;
      gap_q   <= GAP_W'(GAP_CYC);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  always_comb begin
    sel_sck  = is_br ? br_sck_i   : usr_sck_i;
    sel_cs   = is_br ? br_cs_n_i  : usr_cs_n_i;
    sel_dout = is_br ? br_dout_i  : usr_dout_i;
    sel_oe   = is_br ? br_oe_i    : usr_oe_i;
  end

  generate
    if (CS_W > 1) begin : g_cs_guard
      always_comb safe_cs = ($countones(~sel_cs) > 1) ? '1 : sel_cs;
    end else begin : g_cs_pass
      always_comb safe_cs = sel_cs;
    end
  endgenerate

  assign blank_o    = (gap_q != '0);
  assign owner_br_o = is_br;
  assign fl_sck_o   = blank_o ? 1'b0 : sel_sck;
  assign fl_cs_n_o  = blank_o ? '1   : safe_cs;
  assign fl_dout_o  = blank_o ? '0   : sel_dout;
  assign fl_oe_o    = blank_o ? '0   : sel_oe;
endmodule

// File: rtl/flash_share_arbiter.sv
module flash_share_arbiter #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TIMEOUT_MS = 5000,
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned CS_W       = 3,
  parameter int unsigned GAP_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_async_i,
  input  logic              br_start_i,
  input  logic              br_done_i,
  output logic              req_o,
  output logic              br_go_o,
  output logic              timeout_o,
  output logic              proto_err_o,
  input  logic              usr_sck_i,
  input  logic [CS_W-1:0]   usr_cs_n_i,
  input  logic [DATA_W-1:0] usr_dout_i,
  input  logic [DATA_W-1:0] usr_oe_i,
  input  logic              br_sck_i,
  input  logic [CS_W-1:0]   br_cs_n_i,
  input  logic [DATA_W-1:0] br_dout_i,
  input  logic [DATA_W-1:0] br_oe_i,
  input  logic [DATA_W-1:0] fl_din_i,
  output logic [DATA_W-1:0] core_din_o,
  output logic              fl_sck_o,
  output logic [CS_W-1:0]   fl_cs_n_o,
  output logic [DATA_W-1:0] fl_dout_o,
  output logic [DATA_W-1:0] fl_oe_o
);
  localparam int unsigned TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  logic grant_s, owner_br, blank, want_br;

  flash_grant_sync #(.STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (grant_async_i),
    .sync_o  (grant_s)
  );

  flash_req_ctrl #(.TO_CYC(TO_CYC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (br_start_i),
    .done_i      (br_done_i),
    .grant_s_i   (grant_s),
    .owner_br_i  (owner_br),
    .blank_i     (blank),
    .req_o       (req_o),
    .go_o        (br_go_o),
    .timeout_o   (timeout_o),
    .proto_err_o (proto_err_o)
  );

  // bridge keeps the pins until its request falls, even if the grant drops
  assign want_br = req_o && (grant_s || owner_br);

  flash_pin_mux #(
    .DATA_W  (DATA_W),
    .CS_W    (CS_W),
    .GAP_CYC (GAP_CYC)
  ) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .want_br_i  (want_br),
    .usr_sck_i  (usr_sck_i),
    .usr_cs_n_i (usr_cs_n_i),
    .usr_dout_i (usr_dout_i),
    .usr_oe_i   (usr_oe_i),
    .br_sck_i   (br_sck_i),
    .br_cs_n_i  (br_cs_n_i),
    .br_dout_i  (br_dout_i),
    .br_oe_i    (br_oe_i),
    .owner_br_o (owner_br),
    .blank_o    (blank),
    .fl_sck_o   (fl_sck_o),
    .fl_cs_n_o  (fl_cs_n_o),
    .fl_dout_o  (fl_dout_o),
    .fl_oe_o    (fl_oe_o)
  );

  assign core_din_o = fl_din_i;
endmodule

// File: rtl/flash_share_arbiter_chk.sv
module flash_share_arbiter_chk #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned CS_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              br_done_i,
  input logic              req_o,
  input logic              br_go_o,
  input logic              timeout_o,
  input logic              proto_err_o,
  input logic              br_sck_i,
  input logic [CS_W-1:0]   br_cs_n_i,
  input logic [DATA_W-1:0] br_dout_i,
  input logic [DATA_W-1:0] br_oe_i,
  input logic              fl_sck_o,
  input logic [CS_W-1:0]   fl_cs_n_o,
  input logic [DATA_W-1:0] fl_dout_o,
  input logic [DATA_W-1:0] fl_oe_o
);
  p_cs_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~fl_cs_n_o));

  p_go_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_go_o |-> req_o);

  p_go_pins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_go_o && $onehot0(~br_cs_n_i)) |->
      (fl_cs_n_o == br_cs_n_i && fl_dout_o == br_dout_i &&
       fl_oe_o == br_oe_i && fl_sck_o == br_sck_i));

  p_req_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> ($rose(timeout_o) || $past(br_done_i)));

  p_to_drops_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($fell(req_o) && !$past(br_go_o)));

  p_to_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

bind flash_share_arbiter flash_share_arbiter_chk #(
  .DATA_W (DATA_W),
  .CS_W   (CS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_done_i   (br_done_i),
  .req_o       (req_o),
  .br_go_o     (br_go_o),
  .timeout_o   (timeout_o),
  .proto_err_o (proto_err_o),
  .br_sck_i    (br_sck_i),
  .br_cs_n_i   (br_cs_n_i),
  .br_dout_i   (br_dout_i),
  .br_oe_i     (br_oe_i),
  .fl_sck_o    (fl_sck_o),
  .fl_cs_n_o   (fl_cs_n_o),
  .fl_dout_o   (fl_dout_o),
  .fl_oe_o     (fl_oe_o)
);

// File: tb/flash_share_arbiter_tb_top.sv
module flash_share_arbiter_tb_top;
  localparam int TO_CYC = 40;  // CLK_HZ 1000, TIMEOUT_MS 40
  localparam int K_USR = 0, K_BLANK = 1, K_BR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0, start = 1'b0, done = 1'b0;
  logic req, go, to_flag, err_flag;
  logic       usr_sck = 1'b1, br_sck = 1'b1;
  logic [2:0] usr_cs = 3'b111, br_cs = 3'b110;
  logic [3:0] usr_dout = 4'hA, usr_oe = 4'hF, br_dout = 4'h5, br_oe = 4'h3;
  logic [3:0] fl_din = 4'h0, core_din;
  logic       fl_sck;
  logic [2:0] fl_cs;
  logic [3:0] fl_dout, fl_oe;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  int kind_q[$];
  bit go_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_share_arbiter #(
    .CLK_HZ(1000), .TIMEOUT_MS(40), .DATA_W(4), .CS_W(3), .GAP_CYC(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .grant_async_i(grant),
    .br_start_i(start), .br_done_i(done),
    .req_o(req), .br_go_o(go), .timeout_o(to_flag), .proto_err_o(err_flag),
    .usr_sck_i(usr_sck), .usr_cs_n_i(usr_cs), .usr_dout_i(usr_dout), .usr_oe_i(usr_oe),
    .br_sck_i(br_sck), .br_cs_n_i(br_cs), .br_dout_i(br_dout), .br_oe_i(br_oe),
    .fl_din_i(fl_din), .core_din_o(core_din),
    .fl_sck_o(fl_sck), .fl_cs_n_o(fl_cs), .fl_dout_o(fl_dout), .fl_oe_o(fl_oe)
  );

  // R9: more than one active-low select collapses to all high
  function automatic logic [2:0] guard_cs(logic [2:0] c);
    return ($countones(~c) > 1) ? 3'b111 : c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: queue one expected pin owner for the next sample, advance a cycle
  task automatic step(int k, bit g, string t);
    kind_q.push_back(k);
    go_q.push_back(g);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  // monitor: pin ownership compared on every scheduled cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (kind_q.size() > 0) begin
        int   k;
        bit   g;
        string t;
        logic [12:0] exp_v, act_v;
        k = kind_q.pop_front();
        g = go_q.pop_front();
        t = tag_q.pop_front();
        if (k == K_USR)
          exp_v = {guard_cs(usr_cs), usr_dout, usr_oe, usr_sck, g};
        else if (k == K_BR)
          exp_v = {guard_cs(br_cs), br_dout, br_oe, br_sck, g};
        else
          exp_v = {3'b111, 4'h0, 4'h0, 1'b0, g};
        act_v = {fl_cs, fl_dout, fl_oe, fl_sck, go};
        check(t, 32'(act_v), 32'(exp_v));
      end
    end
  end

  // R10: release after done
  task automatic release_op();
    br_cs = 3'b111;
    done  = 1'b1;
    step(K_BR, 1'b0, "R10");
    done = 1'b0;
    check("R10 req low", 32'(req), 32'd0);
    step(K_BLANK, 1'b0, "R4");
    step(K_BLANK, 1'b0, "R4");
    step(K_USR, 1'b0, "R10");
    br_cs = 3'b110;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 req", 32'(req), 32'd0);
    check("R1 go", 32'(go), 32'd0);
    check("R1 flags", 32'({to_flag, err_flag}), 32'd0);
    step(K_USR, 1'b0, "R1");
    step(K_USR, 1'b0, "R1");

    // chip-select guard and data return
    usr_cs = 3'b101; step(K_USR, 1'b0, "R9");
    usr_cs = 3'b100; step(K_USR, 1'b0, "R9");
    usr_cs = 3'b010; step(K_USR, 1'b0, "R9");
    usr_cs = 3'b111;
    fl_din = 4'h9; #1 check("R11", 32'(core_din), 32'h9);
    fl_din = 4'h6; #1 check("R11", 32'(core_din), 32'h6);
    @(negedge clk);

    // grant without request: no effect
    grant = 1'b1;
    for (int i = 0; i < 6; i++) begin
      usr_dout = 4'(i + 1);
      step(K_USR, 1'b0, "R6");
    end
    check("R6 no req", 32'(req), 32'd0);

    // grant before request
    start = 1'b1;
    step(K_USR, 1'b0, "R2");
    start = 1'b0;
    check("R2 req high", 32'(req), 32'd1);
    step(K_BLANK, 1'b0, "R4");
    step(K_BLANK, 1'b0, "R4");
    step(K_BR, 1'b1, "R6");
    for (int i = 0; i < 3; i++) begin
      br_dout = 4'(i + 8);
      step(K_BR, 1'b1, "R6");
    end
    release_op();
    check("R8 no err", 32'(err_flag), 32'd0);
    grant = 1'b0;
    repeat (3) step(K_USR, 1'b0, "R6");

    // grant after request through the synchronizer
    start = 1'b1;
    step(K_USR, 1'b0, "R2");
    start = 1'b0;
    step(K_USR, 1'b0, "R3");
    step(K_USR, 1'b0, "R3");
    grant = 1'b1;
    step(K_USR, 1'b0, "R3");
    step(K_USR, 1'b0, "R3");
    step(K_BLANK, 1'b0, "R3");
    step(K_BLANK, 1'b0, "R3");
    step(K_BR, 1'b1, "R3");

    // grant dropped while request active
    grant = 1'b0;
    for (int i = 0; i < 5; i++) step(K_BR, 1'b1, "R8");
    check("R8 err set", 32'(err_flag), 32'd1);
    check("R8 req held", 32'(req), 32'd1);
    release_op();
    check("R8 err sticky", 32'(err_flag), 32'd1);
    repeat (2) step(K_USR, 1'b0, "R6");

    // switch deferred while user holds a chip select
    usr_cs = 3'b110;
    start  = 1'b1;
    step(K_USR, 1'b0, "R2");
    start = 1'b0;
    grant = 1'b1;
    for (int i = 0; i < 6; i++) step(K_USR, 1'b0, "R5");
    check("R5 no go", 32'(go), 32'd0);
    usr_cs = 3'b111;
    step(K_BLANK, 1'b0, "R5");
    step(K_BLANK, 1'b0, "R4");
    step(K_BR, 1'b1, "R5");
    release_op();

    // back-to-back request with grant held
    start = 1'b1;
    step(K_USR, 1'b0, "R2");
    start = 1'b0;
    step(K_BLANK, 1'b0, "R2");
    step(K_BLANK, 1'b0, "R2");
    step(K_BR, 1'b1, "R2");
    release_op();
    grant = 1'b0;
    repeat (3) step(K_USR, 1'b0, "R6");

    // request timeout
    check("R7 no timeout yet", 32'(to_flag), 32'd0);
    begin
      int hi;
      hi = 0;
      start = 1'b1;
      step(K_USR, 1'b0, "R7");
      start = 1'b0;
      for (int i = 0; i < TO_CYC + 8; i++) begin
        if (req) hi++;
        step(K_USR, 1'b0, "R7");
      end
      check("R7 req cycles", 32'(hi), 32'(TO_CYC));
    end
    check("R7 timeout set", 32'(to_flag), 32'd1);
    check("R7 req low", 32'(req), 32'd0);
    repeat (3) step(K_USR, 1'b0, "R7");
    check("R7 timeout sticky", 32'(to_flag), 32'd1);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule